// File: doc/BRIEF.md
# Virtual Supervisor Top-Interrupt Arbiter

This block builds the status word that a virtualized supervisor reads to learn which interrupt it should take next, and at what priority. It takes up to two candidates and compares them. The first slot holds either a guest external interrupt, picked by a guest-file selector, or an injected external interrupt when no guest file is selected. The second slot holds either an interrupt injected through hypervisor control fields or the most urgent pending local interrupt of the virtual supervisor.

The candidate with the smallest priority number wins. The first slot wins on a tie. A priority-mode bit then decides the reported priority. When the bit is set, the priority is limited to 255, and some zero priorities are raised to 255. When the bit is clear, every winner reports priority 1. The result is placed in a status register whenever the read strobe is asserted. Between strobes the register keeps its value.

Top module: `vs_topint_arb`

## Requirements
- R1: A guest external candidate (ID 9) exists only when all of these hold: `gsel` is nonzero, `gsel` ≤ GUEST_FILES, `ext_en` is 1, and either `gpend[gsel]` or `ext_lpend` is 1.
- R2: The guest external candidate has priority 256, unless `gtop_valid` is 1 and `gtop_prio` is nonzero. In that case its priority is `gtop_prio`.
- R3: When `gsel` is zero, `inj_id` = 9 with `inj_prio` nonzero gives a first-slot candidate of ID 9 at priority `inj_prio`.
- R4: When `inj_en` is 1 and `inj_id` ≠ 9, a second-slot candidate `inj_id` exists at priority `inj_prio`. This holds even when `inj_id` is 0.
- R5: When `inj_en` is 0, the lowest-numbered set bit k of `lpend` in 1..NSRC-1 gives a second-slot candidate at priority `lprio_flat[8k+7:8k]`. This happens only if k ≠ 9. Bit 0 of `lpend` is ignored.
- R6: The candidate with the strictly smallest priority wins. On a tie, the first slot (guest or injected external) wins.
- R7: With `prio_mode` = 1, a winning priority above 255 is reported as 255. A zero priority is reported as 255 when the winning ID is greater than 9. Any other priority is reported unchanged.
- R8: With `prio_mode` = 0, a nonzero winning ID reports priority 1.
- R9: When there is no candidate, or the winning ID is 0, the whole status word is zero.
- R10: `status` has the ID in bits 27:16 and the priority in bits 7:0, with all other bits zero. It resets to zero, loads on a clock edge with `rd_strobe` high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_strobe | input | 1 | Loads the status register |
| gsel | input | 6 | Guest external file selector, 0 = none |
| gpend | input | 64 | Guest external pending bits, indexed by selector |
| ext_en | input | 1 | Virtual supervisor external interrupt enable |
| ext_lpend | input | 1 | Local external pending bit |
| gtop_valid | input | 1 | Guest file top priority is available |
| gtop_prio | input | 8 | Guest file top priority |
| inj_en | input | 1 | Injected interrupt replaces the local candidate |
| inj_id | input | 12 | Injected interrupt ID |
| inj_prio | input | 8 | Injected interrupt priority |
| prio_mode | input | 1 | 1 = report adjusted priority, 0 = report 1 |
| lpend | input | 64 | Pending and enabled local interrupts |
| lprio_flat | input | 512 | Per-source 8-bit priorities, source k at bits 8k+7:8k |
| status | output | 32 | Registered top-interrupt word |

## Verification
The first slot and the second slot can both hold a valid candidate in the same cycle. Their priorities then decide the winner. The bench provokes this in several ways. It enables a guest file while a local interrupt is pending. It also sweeps an injected priority across a fixed guest top priority, including the exact tie value. Each result is compared against a reference model written in the bench, which checks both that the first slot wins ties and that the priority-mode adjustment is applied to whichever slot won.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

  localparam int ID_W   = 12;
  localparam int PRIO_W = 8;
  localparam int CPR_W  = PRIO_W + 1;
  localparam logic [ID_W-1:0] EXT_ID = 12'd9;
  localparam logic [CPR_W-1:0] UNKNOWN_PRIO = 9'd256;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   id;
    logic [CPR_W-1:0]  prio;
  } cand_t;

  // An ID above the external one ranks below it in default order.
  function automatic logic ranks_below_ext(input logic [ID_W-1:0] id);
    return id > EXT_ID;
  endfunction

  function automatic logic [PRIO_W-1:0] adjust_prio(input logic [CPR_W-1:0] p,
                                                    input logic [ID_W-1:0]  id,
                                                    input logic             mode);
    logic [PRIO_W-1:0] r;
    if (!mode)                                   r = 8'd1;
    else if (p[CPR_W-1])                         r = 8'd255;
    else if (p == '0 && ranks_below_ext(id))     r = 8'd255;
    else                                         r = p[PRIO_W-1:0];
    return r;
  endfunction

  function automatic logic [31:0] pack_word(input logic [ID_W-1:0]   id,
                                            input logic [PRIO_W-1:0] p);
    return {4'b0, id, 8'b0, p};
  endfunction

endpackage

// File: rtl/vsa_local_pick.sv
module vsa_local_pick
  import vsa_pkg::*;
#(
  parameter int NSRC = 64
) (
  input  logic [NSRC-1:0]        lpend,
  input  logic [NSRC*PRIO_W-1:0] lprio_flat,
  output cand_t                  loc
);
  localparam int LIDX_W = $clog2(NSRC);

  logic [PRIO_W-1:0] prio_arr [NSRC];
  logic [LIDX_W-1:0] idx;
  logic              found;

  for (genvar g = 0; g < NSRC; g++) begin : g_unpack
    assign prio_arr[g] = lprio_flat[g*PRIO_W +: PRIO_W];
  end

  // Lowest-numbered pending source above zero.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = NSRC - 1; i >= 1; i--) begin
      if (lpend[i]) begin
        idx   = LIDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    loc       = '0;
    loc.id    = ID_W'(idx);
    loc.prio  = {1'b0, prio_arr[idx]};
    loc.valid = found && (ID_W'(idx) != EXT_ID);
  end

endmodule

// File: rtl/vsa_cand_build.sv
module vsa_cand_build
  import vsa_pkg::*;
#(
  parameter int GSEL_W      = 6,
  parameter int GUEST_FILES = 15
) (
  input  logic [GSEL_W-1:0]      gsel,
  input  logic [(1<<GSEL_W)-1:0] gpend,
  input  logic                   ext_en,
  input  logic                   ext_lpend,
  input  logic                   gtop_valid,
  input  logic [PRIO_W-1:0]      gtop_prio,
  input  logic                   inj_en,
  input  logic [ID_W-1:0]        inj_id,
  input  logic [PRIO_W-1:0]      inj_prio,
  input  cand_t                  loc,
  output cand_t                  slot0,
  output cand_t                  slot1,
  output logic                   gext_hit
);
  logic in_range;
  logic ext_pending;

  assign in_range    = (gsel != '0) && (int'(gsel) <= GUEST_FILES);
  assign ext_pending = ext_lpend || gpend[gsel];
  assign gext_hit    = in_range && ext_en && ext_pending;

  always_comb begin
    slot0 = '0;
    if (gsel != '0) begin
      if (gext_hit) begin
        slot0.valid = 1'b1;
        slot0.id    = EXT_ID;
        slot0.prio  = (gtop_valid && gtop_prio != '0) ? {1'b0, gtop_prio} : UNKNOWN_PRIO;
      end
    end else if (inj_id == EXT_ID && inj_prio != '0) begin
      slot0.valid = 1'b1;
      slot0.id    = EXT_ID;
      slot0.prio  = {1'b0, inj_prio};
    end
  end

  always_comb begin
    slot1 = '0;
    if (inj_en) begin
      if (inj_id != EXT_ID) begin
        slot1.valid = 1'b1;
        slot1.id    = inj_id;
        slot1.prio  = {1'b0, inj_prio};
      end
    end else begin
      slot1 = loc;
    end
  end

endmodule

// File: rtl/vsa_arbiter.sv
module vsa_arbiter
  import vsa_pkg::*;
#(
  parameter int NCAND = 2
) (
  input  cand_t [NCAND-1:0] cands,
  output cand_t             win
);
  logic [CPR_W:0] best;

  // Strict less-than keeps the lower slot on ties.
  always_comb begin
    win  = '0;
    best = '1;
    for (int i = 0; i < NCAND; i++) begin
      if (cands[i].valid && {1'b0, cands[i].prio} < best) begin
        win  = cands[i];
        best = {1'b0, cands[i].prio};
      end
    end
  end

endmodule

// File: rtl/vs_topint_arb.sv
module vs_topint_arb
  import vsa_pkg::*;
#(
  parameter int GSEL_W      = 6,
  parameter int GUEST_FILES = 15,
  parameter int NSRC        = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_strobe,
  input  logic [GSEL_W-1:0]        gsel,
  input  logic [(1<<GSEL_W)-1:0]   gpend,
  input  logic                     ext_en,
  input  logic                     ext_lpend,
  input  logic                     gtop_valid,
  input  logic [7:0]               gtop_prio,
  input  logic                     inj_en,
  input  logic [11:0]              inj_id,
  input  logic [7:0]               inj_prio,
  input  logic                     prio_mode,
  input  logic [NSRC-1:0]          lpend,
  input  logic [NSRC*8-1:0]        lprio_flat,
  output logic [31:0]              status
);
  localparam int NCAND = 2;

  cand_t              loc;
  cand_t              slot0;
  cand_t              slot1;
  cand_t              win;
  cand_t [NCAND-1:0]  cands;
  logic               gext_hit;
  logic [PRIO_W-1:0]  adj_prio;
  logic [31:0]        next_word;

  vsa_local_pick #(.NSRC(NSRC)) u_local (
    .lpend      (lpend),
    .lprio_flat (lprio_flat),
    .loc        (loc)
  );

  vsa_cand_build #(.GSEL_W(GSEL_W), .GUEST_FILES(GUEST_FILES)) u_cand (
    .gsel       (gsel),
    .gpend      (gpend),
    .ext_en     (ext_en),
    .ext_lpend  (ext_lpend),
    .gtop_valid (gtop_valid),
    .gtop_prio  (gtop_prio),
    .inj_en     (inj_en),
    .inj_id     (inj_id),
    .inj_prio   (inj_prio),
    .loc        (loc),
    .slot0      (slot0),
    .slot1      (slot1),
    .gext_hit   (gext_hit)
  );

  assign cands[0] = slot0;
  assign cands[1] = slot1;

  vsa_arbiter #(.NCAND(NCAND)) u_arb (
    .cands (cands),
    .win   (win)
  );

  assign adj_prio  = adjust_prio(win.prio, win.id, prio_mode);
  assign next_word = (win.valid && win.id != '0) ? pack_word(win.id, adj_prio) : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= 32'd0;
    else if (rd_strobe) status <= next_word;
  end

  // Guest external slot only appears under an enabled, in-range selector.
  assert_gext_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot0.valid && gsel != '0) |-> (ext_en && int'(gsel) <= GUEST_FILES));

  assert_local_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_en && slot1.valid) |-> (lpend[slot1.id[$clog2(NSRC)-1:0]] && slot1.id != EXT_ID));

  assert_min_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot0.valid |-> (win.valid && win.prio <= slot0.prio));

  assert_min_slot1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot1.valid |-> (win.valid && win.prio <= slot1.prio));

  assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !prio_mode) |=> (status[27:16] == '0 || status[7:0] == 8'd1));

  assert_zero_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[27:16] == '0) |-> (status == 32'd0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(status));

endmodule

// File: tb/vs_topint_arb_tb.sv
module vs_topint_arb_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_strobe = 1'b0;
  logic [5:0]   gsel = '0;
  logic [63:0]  gpend = '0;
  logic         ext_en = 1'b0;
  logic         ext_lpend = 1'b0;
  logic         gtop_valid = 1'b0;
  logic [7:0]   gtop_prio = '0;
  logic         inj_en = 1'b0;
  logic [11:0]  inj_id = '0;
  logic [7:0]   inj_prio = '0;
  logic         prio_mode = 1'b0;
  logic [63:0]  lpend = '0;
  logic [511:0] lprio_flat = '0;
  logic [31:0]  status;

  logic [7:0]   lp [64];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  vs_topint_arb u_dut (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .gsel(gsel), .gpend(gpend),
    .ext_en(ext_en), .ext_lpend(ext_lpend), .gtop_valid(gtop_valid),
    .gtop_prio(gtop_prio), .inj_en(inj_en), .inj_id(inj_id), .inj_prio(inj_prio),
    .prio_mode(prio_mode), .lpend(lpend), .lprio_flat(lprio_flat), .status(status)
  );

  task automatic load_prios();
    for (int i = 0; i < 64; i++) lprio_flat[i*8 +: 8] = lp[i];
  endtask

  // Independent restatement of the requirements.
  function automatic logic [31:0] model();
    int ids [2];
    int prs [2];
    int n = 0;
    int bid = 0;
    int bpr = 1 << 30;
    int k = 0;
    int rep;
    if (gsel != 0) begin
      if (gsel <= 15 && ext_en && (ext_lpend || gpend[gsel])) begin
        ids[n] = 9; prs[n] = (gtop_valid && gtop_prio != 0) ? int'(gtop_prio) : 256; n++;
      end
    end else if (inj_id == 9 && inj_prio != 0) begin
      ids[n] = 9; prs[n] = int'(inj_prio); n++;
    end
    if (inj_en) begin
      if (inj_id != 9) begin ids[n] = int'(inj_id); prs[n] = int'(inj_prio); n++; end
    end else begin
      for (int j = 63; j >= 1; j--) if (lpend[j]) k = j;
      if (k != 0 && k != 9) begin ids[n] = k; prs[n] = int'(lp[k]); n++; end
    end
    for (int j = 0; j < n; j++) if (prs[j] < bpr) begin bid = ids[j]; bpr = prs[j]; end
    if (bid == 0) return 32'd0;
    if (!prio_mode) rep = 1;
    else if (bpr > 255) rep = 255;
    else if (bpr == 0 && bid > 9) rep = 255;
    else rep = bpr;
    return (32'(bid) << 16) | 32'(rep);
  endfunction

  task automatic check_word(input string tag, input logic [31:0] exp);
    checks++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s: status=%h expected=%h", tag, status, exp);
    end
  endtask

  task automatic strobe_check(input string tag);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check_word(tag, model());
  endtask

  task automatic clear_inputs();
    gsel = '0; gpend = '0; ext_en = 0; ext_lpend = 0; gtop_valid = 0; gtop_prio = '0;
    inj_en = 0; inj_id = '0; inj_prio = '0; prio_mode = 0; lpend = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 64; i++) lp[i] = (i % 7 == 0) ? 8'd0 : 8'((i * 29 + 3) % 256);
    load_prios();
    repeat (3) @(negedge clk);
    check_word("R10 reset", 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: guest external selector, enable, pending, top priority
    for (int s = 0; s < 20; s++)
      for (int m = 0; m < 16; m++)
        for (int t = 0; t < 3; t++) begin
          clear_inputs();
          gsel = 6'(s); ext_en = m[0]; ext_lpend = m[1];
          gpend = m[2] ? (64'd1 << s) : ~(64'd1 << s);
          prio_mode = m[3];
          gtop_valid = (t != 0); gtop_prio = (t == 2) ? 8'd40 : 8'd0;
          strobe_check("R1 R2 guest external");
        end

    // R3 R4 R9: injected interrupts with and without a guest file selected
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 3; b++)
        for (int m = 0; m < 8; m++) begin
          clear_inputs();
          inj_id = (a == 0) ? 12'd9 : (a == 1) ? 12'd3 : (a == 2) ? 12'd0 : 12'd300;
          inj_prio = (b == 0) ? 8'd0 : (b == 1) ? 8'd1 : 8'd200;
          inj_en = m[0]; prio_mode = m[1]; lpend = m[2] ? 64'h10 : 64'h0;
          strobe_check("R3 R4 R9 injected");
        end

    // R5 R7 R8: single local pending source, both modes (zero prios at 7, 14, ...)
    for (int k = 0; k < 64; k++)
      for (int m = 0; m < 2; m++) begin
        clear_inputs();
        lpend = 64'd1 << k; prio_mode = m[0];
        strobe_check("R5 R7 R8 local single");
        lpend = lpend | (64'd1 << ((k + 5) % 64));
        strobe_check("R5 lowest pending wins");
      end

    // R6: guest external against local and injected candidates, including ties
    for (int g = 0; g < 5; g++)
      for (int v = 0; v < 4; v++)
        for (int m = 0; m < 2; m++) begin
          clear_inputs();
          gsel = 6'd3; gpend = 64'h8; ext_en = 1; gtop_valid = 1; prio_mode = m[0];
          gtop_prio = (g == 0) ? 8'd0 : (g == 1) ? 8'd5 : (g == 2) ? 8'd20 : (g == 3) ? 8'd100 : 8'd255;
          lp[20] = (v == 0) ? 8'd0 : (v == 1) ? 8'd5 : (v == 2) ? 8'd20 : 8'd255;
          load_prios();
          lpend = 64'd1 << 20;
          strobe_check("R6 guest vs local");
        end
    lp[20] = 8'((20 * 29 + 3) % 256);
    load_prios();
    for (int p = 0; p < 256; p += 5)
      for (int m = 0; m < 2; m++) begin
        clear_inputs();
        gsel = 6'd2; gpend = 64'h4; ext_en = 1; gtop_valid = 1; gtop_prio = 8'd100;
        inj_en = 1; inj_id = 12'd4; inj_prio = 8'(p); prio_mode = m[0];
        strobe_check("R6 guest vs injected");
      end

    // R7: unknown guest priority clamps to 255 in mode, reads 1 otherwise (R8)
    clear_inputs();
    gsel = 6'd15; gpend = 64'h8000; ext_en = 1; prio_mode = 1;
    strobe_check("R7 clamp 256");
    check_word("R7 clamp value", {4'b0, 12'd9, 8'b0, 8'd255});
    prio_mode = 0;
    strobe_check("R8 mode clear");
    check_word("R8 value", {4'b0, 12'd9, 8'b0, 8'd1});

    // R10: no load without strobe
    held = status;
    clear_inputs();
    lpend = 64'h2; prio_mode = 1;
    @(negedge clk);
    @(negedge clk);
    check_word("R10 hold without strobe", held);
    strobe_check("R10 load with strobe");
    check_word("R10 field layout", {4'b0, 12'd1, 8'b0, lp[1]});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule